// File: doc/BRIEF.md
# T3/E3 Receive Framing and Parity Error Counters

This block keeps two saturating 16-bit performance counters beside a T3/E3 receive framer. The first counts framing events. A two-bit selector picks the event source, and the meaning of each selector value depends on whether the line runs in T3 or E3. The second counter records T3 parity errors. It compares the two received P bits with each other and with the parity the framer computed over the information bits.

The framer drives single-cycle strobes for each event it detects, plus a loss-of-frame level. A configuration bit decides whether error counting carries on or stops while frame alignment is lost. The host reads each counter through its own read strobe. During that cycle the output holds the value, and the counter restarts from zero. An event that arrives in the read cycle is counted rather than lost.

Top module: `t3e3_err_cnt`

## Requirements
- R1: While rst_ni is low, both counters read zero.
- R2: With fcnt_mode_i = 2'b00, in T3 or E3, the framing counter adds one for each sync_loss_i strobe. The loss-of-frame gating does not apply in this mode.
- R3: With fcnt_mode_i = 2'b01, in T3 (e3_i = 0) the framing counter adds fbit_err_i + mbit_err_i, so a cycle with both adds two. In E3 (e3_i = 1) it adds the value on fas_bits_i.
- R4: With fcnt_mode_i = 2'b10, the framing counter adds fbit_err_i in T3 and fas_word_err_i in E3.
- R5: With fcnt_mode_i = 2'b11, the framing counter adds mbit_err_i in T3. In E3 it never increments.
- R6: When lof_i = 1 and cnt_in_lof_i = 0, the framing counter in modes 01, 10 and 11 and the parity counter do not increment. With cnt_in_lof_i = 1 they count as usual.
- R7: In T3, a cycle with p_valid_i = 1 adds one to the parity counter when p1_i differs from p2_i, or when both differ from p_calc_i.
- R8: In E3, the parity counter never increments.
- R9: Each counter saturates at 16'hFFFF and does not wrap.
- R10: A read strobe (rd_frm_i or rd_par_i) clears the matching counter at the next clock edge. The increment from an event in the read cycle is kept, so the counter then holds that increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| e3_i | input | 1 | 1 selects E3, 0 selects T3 |
| fcnt_mode_i | input | 2 | Framing-counter event selector |
| cnt_in_lof_i | input | 1 | 1 keeps error counting active during loss of frame |
| lof_i | input | 1 | Loss-of-frame level |
| sync_loss_i | input | 1 | Strobe: receive synchronisation lost |
| fbit_err_i | input | 1 | Strobe: T3 F-bit error |
| mbit_err_i | input | 1 | Strobe: T3 M-bit error |
| fas_bits_i | input | 4 | Number of errored bits in an E3 alignment word |
| fas_word_err_i | input | 1 | Strobe: E3 alignment word in error |
| p_valid_i | input | 1 | Strobe: P bits and computed parity are valid |
| p1_i | input | 1 | First received P bit |
| p2_i | input | 1 | Second received P bit |
| p_calc_i | input | 1 | Parity computed over the information bits |
| rd_frm_i | input | 1 | Host read-and-clear of the framing counter |
| rd_par_i | input | 1 | Host read-and-clear of the parity counter |
| frm_cnt_o | output | 16 | Framing counter value |
| par_cnt_o | output | 16 | Parity counter value |

## Verification
Each counter is a single register stage. Events and reads present before a rising edge therefore appear on frm_cnt_o and par_cnt_o right after that edge, one cycle after the stimulus. The bench drives inputs on the falling edge and updates its behavioural model on the rising edge. It then compares both outputs on the next falling edge, so every comparison sees the result of exactly one edge. The saturation checks run long enough to fill each counter. They then compare the held value again after more events.

// File: rtl/t3e3_err_cnt_pkg.sv
package t3e3_err_cnt_pkg;
  typedef enum logic [1:0] {
    FCNT_SYNC = 2'b00,
    FCNT_FM   = 2'b01,
    FCNT_F    = 2'b10,
    FCNT_M    = 2'b11
  } fcnt_mode_e;
endpackage

// File: rtl/t3e3_frm_evt_sel.sv
module t3e3_frm_evt_sel
  import t3e3_err_cnt_pkg::*;
#(
  parameter int unsigned INC_W = 4
) (
  input  logic             e3_i,
  input  logic [1:0]       mode_i,
  input  logic             gate_i,
  input  logic             sync_loss_i,
  input  logic             fbit_err_i,
  input  logic             mbit_err_i,
  input  logic [INC_W-1:0] fas_bits_i,
  input  logic             fas_word_err_i,
  output logic [INC_W-1:0] inc_o
);
  fcnt_mode_e mode;
  logic [INC_W-1:0] raw;

  assign mode = fcnt_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      FCNT_SYNC: raw = INC_W'(sync_loss_i);
      FCNT_FM:   raw = e3_i ? fas_bits_i : INC_W'(fbit_err_i) + INC_W'(mbit_err_i);
      FCNT_F:    raw = e3_i ? INC_W'(fas_word_err_i) : INC_W'(fbit_err_i);
      FCNT_M:    raw = e3_i ? '0 : INC_W'(mbit_err_i);
      default:   raw = '0;
    endcase
  end

  // loss-of-sync counting is never gated, only bit/word errors
  assign inc_o = (gate_i && mode != FCNT_SYNC) ? '0 : raw;
endmodule

// File: rtl/t3e3_par_chk.sv
module t3e3_par_chk (
  input  logic e3_i,
  input  logic gate_i,
  input  logic valid_i,
  input  logic p1_i,
  input  logic p2_i,
  input  logic calc_i,
  output logic err_o
);
  logic mismatch;
  // P bits disagree, or agree with each other but not with the computed parity
  assign mismatch = (p1_i ^ p2_i) | (p1_i ^ calc_i);
  assign err_o    = valid_i & ~e3_i & ~gate_i & mismatch;
endmodule

// File: rtl/t3e3_sat_cnt.sv
module t3e3_sat_cnt #(
  parameter int unsigned W     = 16,
  parameter int unsigned INC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [W-1:0]     cnt_o
);
  logic [W-1:0] cnt_q, base;
  logic [W:0]   sum;

  assign base = clr_i ? '0 : cnt_q;
  assign sum  = {1'b0, base} + {{(W+1-INC_W){1'b0}}, inc_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (sum[W]) cnt_q <= '1;
    else             cnt_q <= sum[W-1:0];
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/t3e3_err_cnt.sv
module t3e3_err_cnt #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned FAS_W = 10,
  localparam int unsigned INC_W = $clog2(FAS_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             e3_i,
  input  logic [1:0]       fcnt_mode_i,
  input  logic             cnt_in_lof_i,
  input  logic             lof_i,
  input  logic             sync_loss_i,
  input  logic             fbit_err_i,
  input  logic             mbit_err_i,
  input  logic [INC_W-1:0] fas_bits_i,
  input  logic             fas_word_err_i,
  input  logic             p_valid_i,
  input  logic             p1_i,
  input  logic             p2_i,
  input  logic             p_calc_i,
  input  logic             rd_frm_i,
  input  logic             rd_par_i,
  output logic [CNT_W-1:0] frm_cnt_o,
  output logic [CNT_W-1:0] par_cnt_o
);
  logic             gate;
  logic [INC_W-1:0] frm_inc;
  logic             par_err;

  assign gate = lof_i & ~cnt_in_lof_i;

  t3e3_frm_evt_sel #(.INC_W(INC_W)) i_frm_sel (
    .e3_i          (e3_i),
    .mode_i        (fcnt_mode_i),
    .gate_i        (gate),
    .sync_loss_i   (sync_loss_i),
    .fbit_err_i    (fbit_err_i),
    .mbit_err_i    (mbit_err_i),
    .fas_bits_i    (fas_bits_i),
    .fas_word_err_i(fas_word_err_i),
    .inc_o         (frm_inc)
  );

  t3e3_par_chk i_par_chk (
    .e3_i   (e3_i),
    .gate_i (gate),
    .valid_i(p_valid_i),
    .p1_i   (p1_i),
    .p2_i   (p2_i),
    .calc_i (p_calc_i),
    .err_o  (par_err)
  );

  t3e3_sat_cnt #(.W(CNT_W), .INC_W(INC_W)) i_frm_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (rd_frm_i),
    .inc_i (frm_inc),
    .cnt_o (frm_cnt_o)
  );

  t3e3_sat_cnt #(.W(CNT_W), .INC_W(1)) i_par_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (rd_par_i),
    .inc_i (par_err),
    .cnt_o (par_cnt_o)
  );
endmodule

// File: rtl/t3e3_err_cnt_chk.sv
module t3e3_err_cnt_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned FAS_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             e3_i,
  input logic [1:0]       fcnt_mode_i,
  input logic             cnt_in_lof_i,
  input logic             lof_i,
  input logic             rd_frm_i,
  input logic             rd_par_i,
  input logic [CNT_W-1:0] frm_cnt_o,
  input logic [CNT_W-1:0] par_cnt_o
);
  localparam logic [CNT_W-1:0] MAX = '1;

  // R1
  always_comb if (!rst_ni) begin
    reset_zero_chk: assert (frm_cnt_o == '0 && par_cnt_o == '0);
  end

  // R5
  e3_mode3_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e3_i && fcnt_mode_i == 2'b11 && !rd_frm_i) |=> $stable(frm_cnt_o));

  // R6
  lof_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lof_i && !cnt_in_lof_i && fcnt_mode_i != 2'b00 && !rd_frm_i && !rd_par_i)
    |=> ($stable(frm_cnt_o) && $stable(par_cnt_o)));

  // R8
  e3_par_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e3_i && !rd_par_i) |=> $stable(par_cnt_o));

  // R9
  no_wrap_frm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_cnt_o == MAX && !rd_frm_i) |=> frm_cnt_o == MAX);

  // R9
  no_wrap_par_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_cnt_o == MAX && !rd_par_i) |=> par_cnt_o == MAX);

  // R10
  rd_frm_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_frm_i |=> frm_cnt_o <= CNT_W'(FAS_W + 5));

  // R10
  rd_par_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_par_i |=> par_cnt_o <= CNT_W'(1));
endmodule

bind t3e3_err_cnt t3e3_err_cnt_chk #(.CNT_W(CNT_W), .FAS_W(FAS_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .e3_i        (e3_i),
  .fcnt_mode_i (fcnt_mode_i),
  .cnt_in_lof_i(cnt_in_lof_i),
  .lof_i       (lof_i),
  .rd_frm_i    (rd_frm_i),
  .rd_par_i    (rd_par_i),
  .frm_cnt_o   (frm_cnt_o),
  .par_cnt_o   (par_cnt_o)
);

// File: tb/test_t3e3_err_cnt.sv
`timescale 1ns/1ps
module test_t3e3_err_cnt;
  logic clk = 0, rst_ni = 0;
  logic e3 = 0, cil = 0, lof = 0;
  logic [1:0] mode = 0;
  logic sync_loss = 0, fbit = 0, mbit = 0, fas_word = 0;
  logic [3:0] fas_bits = 0;
  logic pv = 0, p1 = 0, p2 = 0, pc = 0, rd_frm = 0, rd_par = 0;
  logic [15:0] frm_cnt, par_cnt;

  int checks = 0, errors = 0;
  int m_frm = 0, m_par = 0;
  string req = "";
  bit done = 0;

  always #5 clk = ~clk;

  t3e3_err_cnt i_t3e3_err_cnt (
    .clk_i(clk), .rst_ni(rst_ni), .e3_i(e3), .fcnt_mode_i(mode),
    .cnt_in_lof_i(cil), .lof_i(lof), .sync_loss_i(sync_loss),
    .fbit_err_i(fbit), .mbit_err_i(mbit), .fas_bits_i(fas_bits),
    .fas_word_err_i(fas_word), .p_valid_i(pv), .p1_i(p1), .p2_i(p2),
    .p_calc_i(pc), .rd_frm_i(rd_frm), .rd_par_i(rd_par),
    .frm_cnt_o(frm_cnt), .par_cnt_o(par_cnt)
  );

  // behavioural reference, updated on each rising edge
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_frm <= 0; m_par <= 0;
    end else begin
      int fi, pi, nf, np;
      bit hold;
      hold = lof && !cil;
      fi = 0;
      if (mode == 0) fi = int'(sync_loss);
      else if (!hold) begin
        if (mode == 1) fi = e3 ? int'(fas_bits) : int'(fbit) + int'(mbit);
        else if (mode == 2) fi = e3 ? int'(fas_word) : int'(fbit);
        else fi = e3 ? 0 : int'(mbit);
      end
      pi = (!e3 && pv && !hold && ((p1 != p2) || (p1 != pc))) ? 1 : 0;
      nf = (rd_frm ? 0 : m_frm) + fi;
      np = (rd_par ? 0 : m_par) + pi;
      m_frm <= (nf > 65535) ? 65535 : nf;
      m_par <= (np > 65535) ? 65535 : np;
    end
  end

  always @(negedge clk) if (rst_ni && req != "") begin
    checks++;
    if (frm_cnt != 16'(m_frm) || par_cnt != 16'(m_par)) begin
      errors++;
      $display("FAIL %s frm=%0d/%0d par=%0d/%0d (actual/expected)", req,
               frm_cnt, m_frm, par_cnt, m_par);
    end
  end

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic idle();
    sync_loss = 0; fbit = 0; mbit = 0; fas_word = 0; fas_bits = 0;
    pv = 0; rd_frm = 0; rd_par = 0;
  endtask

  task automatic rnd(int n, bit rd_on);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sync_loss = 1'($urandom); fbit = 1'($urandom); mbit = 1'($urandom);
      fas_word = 1'($urandom); fas_bits = 4'($urandom_range(0, 10));
      pv = 1'($urandom); p1 = 1'($urandom); p2 = 1'($urandom); pc = 1'($urandom);
      rd_frm = rd_on && ($urandom_range(0, 7) == 0);
      rd_par = rd_on && ($urandom_range(0, 7) == 0);
    end
    @(negedge clk); idle();
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", int'(frm_cnt), 0);
    chk("R1", int'(par_cnt), 0);
    rst_ni = 1;
    // R1 reset state compared after release
    req = "R1"; @(negedge clk);
    req = "R2"; mode = 0;
    for (int k = 0; k < 4; k++) begin
      e3 = k[0]; lof = k[1]; cil = 0; rnd(40, 1);
    end
    lof = 0;
    req = "R3"; mode = 1; e3 = 0; rnd(60, 1); e3 = 1; rnd(60, 1);
    // R3: both F and M in one cycle adds two
    e3 = 0; @(negedge clk); rd_frm = 1; @(negedge clk); idle(); fbit = 1; mbit = 1;
    @(negedge clk); idle(); chk("R3", int'(frm_cnt), 2);
    req = "R4"; mode = 2; e3 = 0; rnd(60, 1); e3 = 1; rnd(60, 1);
    req = "R5"; mode = 3; e3 = 0; rnd(60, 1); e3 = 1; rnd(60, 1);
    req = "R6"; e3 = 0;
    for (int k = 0; k < 8; k++) begin
      mode = 2'(k); cil = k[2]; lof = 1; rnd(30, 1); lof = 0; rnd(10, 1);
    end
    cil = 0;
    req = "R7"; e3 = 0; mode = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); pv = 1; p1 = k[0]; p2 = k[1]; pc = k[2];
    end
    @(negedge clk); idle(); rnd(60, 1);
    req = "R8"; e3 = 1; rnd(80, 0); e3 = 0;
    req = "R10"; mode = 1;
    @(negedge clk); rd_frm = 1; rd_par = 1; fbit = 1; mbit = 0; pv = 1; p1 = 1; p2 = 0;
    @(negedge clk); idle();
    chk("R10", int'(frm_cnt), 1); chk("R10", int'(par_cnt), 1);
    rnd(100, 1);
    req = "R9"; e3 = 1; mode = 1;
    @(negedge clk); fas_bits = 10;
    repeat (6600) @(negedge clk);
    chk("R9", int'(frm_cnt), 65535);
    e3 = 0; fas_bits = 0; pv = 1; p1 = 1; p2 = 0;
    repeat (65600) @(negedge clk);
    chk("R9", int'(par_cnt), 65535);
    chk("R9", int'(frm_cnt), 65535);
    idle(); @(negedge clk);
    req = "R10"; rd_frm = 1; rd_par = 1; @(negedge clk); idle();
    chk("R10", int'(frm_cnt), 0); chk("R10", int'(par_cnt), 0);
    req = ""; done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule